// File: doc/BRIEF.md
# Core Deep-Sleep Context Save Sequencer

This block runs one core into and out of its deepest power state. In that state the core supply drops so low that the core keeps no architectural state. An entry request comes from either of two sources. One is an I/O read of the deep-level address in the processor control block. The other is a monitor-wait request that carries the deep-state hint. After an entry request the sequencer copies every word of the core's context register file into a per-core state memory. That memory sits on the always-on I/O supply. Only after the last word is stored does the sequencer ask the voltage interface to lower the core supply.

On a wake event the sequencer releases the low-voltage request and waits for the regulator to report a settled supply. It then copies the context back word by word and returns the core to run. A wake that arrives while the save is still in progress is held, so a save always completes. The core context is modelled as a word array that the core can write and read while it runs. When the supply is lowered, that array is cleared to model the lost state.

Top module: `core_deep_sleep`

## Requirements
- R1: In RUN, `io_rd_i` high with `io_addr_i` equal to `LVL6_ADDR` (default 16'h0416) moves the state to SAVE at the next clock edge; a read of any other address is ignored and the state stays RUN.
- R2: In RUN, `mwait_i` high with `mwait_hint_i` equal to `DEEP_HINT` (default 4'h6) moves the state to SAVE at the next edge; any other hint is ignored.
- R3: `state_o` encodes RUN=0, SAVE=1, LOWER_V=2, DEEP=3, RAISE_V=4, RESTORE=5. SAVE lasts exactly `N_WORDS` cycles, storing one context word per clock, and then goes to LOWER_V. `save_done_o` is high for exactly the one LOWER_V cycle.
- R4: `vlow_req_o` is high only in LOWER_V and DEEP, so it never rises before `save_done_o`.
- R5: When LOWER_V is entered, the core context reads as zero until the restore.
- R6: A `wake_i` pulse during SAVE or LOWER_V is held pending. The save is not cut short, DEEP lasts one cycle, and then the state goes to RAISE_V.
- R7: In DEEP, `wake_i` moves the state to RAISE_V at the next edge. In RUN, `wake_i` has no effect.
- R8: RAISE_V holds while `vreg_ok_i` is low and moves to RESTORE at the first edge where it is high.
- R9: RESTORE lasts `N_WORDS` cycles, writing back the saved words, and then returns to RUN with every context word equal to its value at entry.
- R10: `core_busy_o` is high in every state except RUN. Core context writes (`ctx_we_i`) while busy are ignored.
- R11: After reset the state is RUN, `core_busy_o`, `vlow_req_o` and `save_done_o` are low, and every context word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O read address |
| mwait_i | input | 1 | Monitor-wait request |
| mwait_hint_i | input | 4 | Target-state hint of the wait |
| wake_i | input | 1 | Wake event |
| vreg_ok_i | input | 1 | Core supply settled at nominal voltage |
| ctx_we_i | input | 1 | Core context write enable |
| ctx_addr_i | input | AW | Context word address (write and read) |
| ctx_wdata_i | input | 32 | Context write data |
| ctx_rdata_o | output | 32 | Context word at `ctx_addr_i` |
| vlow_req_o | output | 1 | Request to lower core supply to the deep-state voltage |
| save_done_o | output | 1 | Pulse: last context word stored |
| core_busy_o | output | 1 | Core held outside RUN |
| state_o | output | 3 | Sequencer state code |

## Verification
Every state change is registered once. A trigger, wake or `vreg_ok_i` driven before an edge shows on `state_o` right after that edge. SAVE and RESTORE each span exactly `N_WORDS` edges, and `save_done_o` and `vlow_req_o` appear together with LOWER_V, one edge after the last save write. The bench drives inputs just after the falling edge and samples just before the next one, counting edges from the trigger to predict each state. The restored context is compared with a bench copy that tracks only the writes made in RUN.

// File: rtl/core_deep_sleep_pkg.sv
package core_deep_sleep_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SAVE    = 3'd1,
    ST_LOWER_V = 3'd2,
    ST_DEEP    = 3'd3,
    ST_RAISE_V = 3'd4,
    ST_RESTORE = 3'd5
  } seq_state_e;
endpackage

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int N_WORDS = 8,
  parameter int DW      = 32,
  localparam int AW     = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_addr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          seq_we_i,
  input  logic [AW-1:0] seq_addr_i,
  input  logic [DW-1:0] seq_wdata_i,
  input  logic          clear_i,
  output logic [DW-1:0] core_rdata_o,
  output logic [DW-1:0] seq_rdata_o
);
  logic [DW-1:0] words_q [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       words_q[g] <= '0;
      else if (clear_i)                                  words_q[g] <= '0;
      else if (seq_we_i && seq_addr_i == AW'(g))         words_q[g] <= seq_wdata_i;
      else if (core_we_i && core_addr_i == AW'(g))       words_q[g] <= core_wdata_i;
    end
  end

  assign core_rdata_o = words_q[core_addr_i];
  assign seq_rdata_o  = words_q[seq_addr_i];
endmodule

// File: rtl/ctx_state_mem.sv
// Storage on the always-on domain: no reset, contents kept through deep state.
module ctx_state_mem #(
  parameter int N_WORDS = 8,
  parameter int DW      = 32,
  localparam int AW     = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [N_WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/deep_seq_fsm.sv
module deep_seq_fsm
  import core_deep_sleep_pkg::*;
#(
  parameter int N_WORDS = 8,
  localparam int AW     = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enter_i,
  input  logic          wake_i,
  input  logic          vreg_ok_i,
  output seq_state_e    state_o,
  output logic [AW-1:0] cnt_o,
  output logic          mem_we_o,
  output logic          rf_we_o,
  output logic          rf_clear_o,
  output logic          save_done_o,
  output logic          vlow_req_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] LAST = AW'(N_WORDS - 1);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] cnt_q;
  logic          wake_pend_q, save_done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (enter_i) state_d = ST_SAVE;
      ST_SAVE:    if (cnt_q == LAST) state_d = ST_LOWER_V;
      ST_LOWER_V: state_d = ST_DEEP;
      ST_DEEP:    if (wake_i || wake_pend_q) state_d = ST_RAISE_V;
      ST_RAISE_V: if (vreg_ok_i) state_d = ST_RESTORE;
      ST_RESTORE: if (cnt_q == LAST) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      cnt_q       <= '0;
      wake_pend_q <= 1'b0;
      save_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      save_done_q <= (state_q == ST_SAVE) && (cnt_q == LAST);
      if (state_q == ST_SAVE || state_q == ST_RESTORE) cnt_q <= cnt_q + 1'b1;
      if (state_d == ST_SAVE || state_d == ST_RESTORE) begin
        if (state_q != state_d) cnt_q <= '0;
      end
      // hold early wake so the save always completes
      if (state_q == ST_DEEP) wake_pend_q <= 1'b0;
      else if (wake_i && (state_q == ST_SAVE || state_q == ST_LOWER_V)) wake_pend_q <= 1'b1;
    end
  end

  assign state_o     = state_q;
  assign cnt_o       = cnt_q;
  assign mem_we_o    = (state_q == ST_SAVE);
  assign rf_we_o     = (state_q == ST_RESTORE);
  assign rf_clear_o  = (state_q == ST_SAVE) && (cnt_q == LAST);
  assign save_done_o = save_done_q;
  assign vlow_req_o  = (state_q == ST_LOWER_V) || (state_q == ST_DEEP);
  assign busy_o      = (state_q != ST_RUN);
endmodule

// File: rtl/core_deep_sleep.sv
module core_deep_sleep
  import core_deep_sleep_pkg::*;
#(
  parameter int          N_WORDS   = 8,
  parameter logic [15:0] LVL6_ADDR = 16'h0416,
  parameter logic [3:0]  DEEP_HINT = 4'h6,
  localparam int         AW        = $clog2(N_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_rd_i,
  input  logic [15:0]   io_addr_i,
  input  logic          mwait_i,
  input  logic [3:0]    mwait_hint_i,
  input  logic          wake_i,
  input  logic          vreg_ok_i,
  input  logic          ctx_we_i,
  input  logic [AW-1:0] ctx_addr_i,
  input  logic [31:0]   ctx_wdata_i,
  output logic [31:0]   ctx_rdata_o,
  output logic          vlow_req_o,
  output logic          save_done_o,
  output logic          core_busy_o,
  output logic [2:0]    state_o
);
  seq_state_e    state;
  logic [AW-1:0] cnt;
  logic          enter, mem_we, rf_we, rf_clear, busy;
  logic [31:0]   rf_seq_rdata, mem_rdata;

  assign enter = (io_rd_i && io_addr_i == LVL6_ADDR) ||
                 (mwait_i && mwait_hint_i == DEEP_HINT);

  deep_seq_fsm #(.N_WORDS(N_WORDS)) u_fsm (
    .clk_i, .rst_ni,
    .enter_i     (enter),
    .wake_i,
    .vreg_ok_i,
    .state_o     (state),
    .cnt_o       (cnt),
    .mem_we_o    (mem_we),
    .rf_we_o     (rf_we),
    .rf_clear_o  (rf_clear),
    .save_done_o,
    .vlow_req_o,
    .busy_o      (busy)
  );

  ctx_regfile #(.N_WORDS(N_WORDS), .DW(32)) u_rf (
    .clk_i, .rst_ni,
    .core_we_i    (ctx_we_i && !busy),
    .core_addr_i  (ctx_addr_i),
    .core_wdata_i (ctx_wdata_i),
    .seq_we_i     (rf_we),
    .seq_addr_i   (cnt),
    .seq_wdata_i  (mem_rdata),
    .clear_i      (rf_clear),
    .core_rdata_o (ctx_rdata_o),
    .seq_rdata_o  (rf_seq_rdata)
  );

  ctx_state_mem #(.N_WORDS(N_WORDS), .DW(32)) u_mem (
    .clk_i,
    .we_i    (mem_we),
    .addr_i  (cnt),
    .wdata_i (rf_seq_rdata),
    .rdata_o (mem_rdata)
  );

  assign core_busy_o = busy;
  assign state_o     = state;
endmodule

// File: rtl/core_deep_sleep_chk.sv
module core_deep_sleep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wake_i,
  input logic       vreg_ok_i,
  input logic       vlow_req_o,
  input logic       save_done_o,
  input logic       core_busy_o,
  input logic [2:0] state_o
);
  assert_vlow_after_save_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vlow_req_o) |-> save_done_o);

  assert_vlow_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_req_o |-> core_busy_o);

  assert_save_no_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 |=> (state_o == 3'd1 || state_o == 3'd2));

  assert_raise_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !vreg_ok_i) |=> state_o == 3'd4);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_done_o |=> !save_done_o);

  assert_deep_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && wake_i) |=> state_o == 3'd4);
endmodule

bind core_deep_sleep core_deep_sleep_chk u_chk (
  .clk_i, .rst_ni, .wake_i, .vreg_ok_i, .vlow_req_o,
  .save_done_o, .core_busy_o, .state_o
);

// File: tb/core_deep_sleep_test.sv
module core_deep_sleep_test;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_rd = 0, mwait = 0, wake = 0, vreg_ok = 0, ctx_we = 0;
  logic [15:0] io_addr = '0;
  logic [3:0]  hint = '0;
  logic [AW-1:0] ctx_addr = '0;
  logic [31:0] ctx_wdata = '0, ctx_rdata;
  logic vlow, sdone, busy;
  logic [2:0] st;

  int n_tests = 0, n_fail = 0;
  logic [31:0] model [N];

  always #10 clk = ~clk;

  core_deep_sleep uut (
    .clk_i(clk), .rst_ni(rst_n), .io_rd_i(io_rd), .io_addr_i(io_addr),
    .mwait_i(mwait), .mwait_hint_i(hint), .wake_i(wake), .vreg_ok_i(vreg_ok),
    .ctx_we_i(ctx_we), .ctx_addr_i(ctx_addr), .ctx_wdata_i(ctx_wdata),
    .ctx_rdata_o(ctx_rdata), .vlow_req_o(vlow), .save_done_o(sdone),
    .core_busy_o(busy), .state_o(st)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance one edge; inputs change after negedge, sampling just before next posedge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] rnd_word();
    return $urandom;
  endfunction

  task automatic write_ctx(int a, logic [31:0] d, bit track);
    ctx_we = 1; ctx_addr = AW'(a); ctx_wdata = d;
    step();
    ctx_we = 0;
    if (track) model[a] = d;
  endtask

  task automatic check_ctx(string req, bit zero);
    for (int i = 0; i < N; i++) begin
      ctx_addr = AW'(i); #1;
      check(req, ctx_rdata, zero ? 32'h0 : model[i]);
    end
  endtask

  // full round trip; src 0 = I/O read, 1 = monitor-wait
  task automatic round(bit src, bit early_wake, int vdelay);
    for (int i = 0; i < N; i++) write_ctx(i, rnd_word(), 1);
    if (src) begin mwait = 1; hint = 4'h6; end
    else     begin io_rd = 1; io_addr = 16'h0416; end
    step();
    mwait = 0; io_rd = 0;
    check(src ? "R2 enter" : "R1 enter", st, 3'd1);
    check("R10 busy", busy, 1);
    for (int i = 1; i < N; i++) begin
      if (early_wake && i == 2) wake = 1;
      step();
      wake = 0;
      check("R3 save len", st, 3'd1);
      check("R4 no vlow in save", vlow, 0);
    end
    step();
    check("R3 lower", st, 3'd2);
    check("R3 done", sdone, 1);
    check("R4 vlow", vlow, 1);
    step();
    check("R3 done pulse", sdone, 0);
    check("R4 deep", st, 3'd3);
    check_ctx("R5 cleared", 1);
    // write during deep is ignored
    write_ctx(0, 32'hDEAD_BEEF, 0);
    if (early_wake) begin
      check("R6 pending wake", st, 3'd4);
    end else begin
      check("R7 stay deep", st, 3'd3);
      wake = 1; step(); wake = 0;
      check("R7 wake", st, 3'd4);
    end
    check("R4 vlow off", vlow, 0);
    for (int i = 0; i < vdelay; i++) begin
      step();
      check("R8 wait", st, 3'd4);
    end
    vreg_ok = 1; step(); vreg_ok = 0;
    check("R8 restore", st, 3'd5);
    for (int i = 1; i < N; i++) begin
      step();
      check("R9 restore len", st, 3'd5);
    end
    step();
    check("R9 run", st, 3'd0);
    check("R10 idle", busy, 0);
    check_ctx("R9 ctx", 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R11 state", st, 3'd0);
    check("R11 busy", busy, 0);
    check("R11 vlow", vlow, 0);
    check("R11 done", sdone, 0);
    for (int i = 0; i < N; i++) model[i] = 0;
    check_ctx("R11 ctx", 0);
    rst_n = 1;
    step();
    // ignored triggers
    io_rd = 1; io_addr = 16'h0415; step(); io_rd = 0;
    check("R1 wrong addr", st, 3'd0);
    mwait = 1; hint = 4'h5; step(); mwait = 0;
    check("R2 wrong hint", st, 3'd0);
    wake = 1; step(); wake = 0;
    check("R7 wake in run", st, 3'd0);
    round(0, 0, 0);
    round(1, 1, 3);
    for (int r = 0; r < 6; r++) round(1'($urandom), 1'($urandom), int'($urandom % 5));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule